// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits between a host-side request port and an existing management-bus master. The master exposes a simple one-register-at-a-time read/write port. The block serves a switch whose internal register space has two levels: a device address selects a register bank, and a register address selects a word inside that bank. That whole space must be reached through a single bus address.

The bus address of the switch is sampled when a request is accepted. If it is zero, the block forwards the request as one direct bus transaction, with the device address used as the bus address. If it is non-zero, the block drives an indirection sequence through two registers at that bus address. A command register sits at offset 0 and a data register at offset 1. Each command is preceded and followed by polling of the command register's busy bit. The poll is bounded, and it ends in a timeout error if the bit stays set. A failed bus transaction aborts the sequence with the same error response.

Top module: `smi_indirect_seq`

## Requirements
- R1: With a sampled bus address of zero, a request produces exactly one bus transaction with bus address = device address, register = register address, and the same direction and write data. Done follows one cycle after that transaction completes, with rdata = the returned word for a read and 0 for a write.
- R2: With a non-zero sampled bus address, every bus transaction of the request targets that bus address, using register 0 for the command and register 1 for the data.
- R3: The command word written to register 0 has bit 15 = 1 (start/busy), bit 12 = 1, bits 11:10 = 2'b10 for a read or 2'b01 for a write, bits 9:5 = device address and bits 4:0 = register address. All other bits are 0.
- R4: An indirect request starts with reads of register 0. These repeat while the returned bit 15 is 1, and the sequence moves on at the first read with bit 15 = 0.
- R5: An indirect read runs: pre-poll, write of the read command, post-poll, one read of register 1. It then reports done with rdata equal to the full 16-bit word returned by that read.
- R6: An indirect write runs: pre-poll, write of the data word to register 1, write of the write command, post-poll. It then reports done with rdata = 0.
- R7: If POLL_LIMIT consecutive polls in one poll phase return bit 15 = 1, the request ends with done and err both high, rdata = 0, and no further bus transaction.
- R8: A bus transaction completing with its error flag high ends the request at once with done and err both high and rdata = 0.
- R9: req_ready is high exactly when no bus transaction is pending (req_ready equals the inverse of mb_valid). Done is a single-cycle pulse.
- R10: The bus address is sampled at request acceptance. A change of cfg_bus_addr during a request has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus_addr | input | 5 | Bus address of the switch; 0 selects direct access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when valid and ready |
| req_dev | input | 5 | Device (bank) address |
| req_reg | input | 5 | Register address in the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error (timeout or bus error), valid with done |
| rdata | output | 16 | Read data, valid with done |
| mb_valid | output | 1 | Bus transaction pending; fields held until mb_done |
| mb_write | output | 1 | Bus transaction direction |
| mb_phy | output | 5 | Bus address of the transaction |
| mb_reg | output | 5 | Register of the transaction |
| mb_wdata | output | 16 | Write data of the transaction |
| mb_done | input | 1 | Transaction complete (one cycle) |
| mb_err | input | 1 | Transaction failed, valid with mb_done |
| mb_rdata | input | 16 | Read data, valid with mb_done |

## Verification
On every cycle, the assertions check several port-level relations. Indirect transactions stay at the sampled bus address and use only registers 0 and 1. Every command word has the fixed start, style and opcode bits. A request always opens with a command-register read, and a bus error is followed by an error response. Ready never overlaps a pending transaction, done stays a single pulse, and err never carries read data. Only the bench scenarios can show the exact order and count of transactions, the returned data, the timeout count in each of the two poll phases, and that a mid-request change of the configured address is ignored.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] REG_CMD  = 5'd0;
    localparam logic [ADDR_W-1:0] REG_DATA = 5'd1;

    localparam int BUSY_BIT  = 15;
    localparam int STYLE_BIT = 12;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIRECT,
        S_PRE_POLL,
        S_WR_DATA,
        S_CMD,
        S_POST_POLL,
        S_RD_DATA
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] bus;
        logic [ADDR_W-1:0] dev;
        logic [ADDR_W-1:0] rg;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;
endpackage

// File: rtl/smi_cmd_fmt.sv
module smi_cmd_fmt
    import smi_seq_pkg::*;
(
    input  logic              is_write,
    input  logic [ADDR_W-1:0] dev,
    input  logic [ADDR_W-1:0] rg,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word            = '0;
        word[BUSY_BIT]  = 1'b1;
        word[STYLE_BIT] = 1'b1;
        word[11:10]     = is_write ? OP_WR : OP_RD;
        word[9:5]       = dev;
        word[4:0]       = rg;
    end
endmodule

// File: rtl/smi_poll_limit.sv
module smi_poll_limit #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(LIMIT - 1));

    initial begin
        a_r7_limit_positive: assert (LIMIT >= 1);
    end
endmodule

// File: rtl/smi_indirect_seq.sv
module smi_indirect_seq
    import smi_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_bus_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mb_valid,
    output logic              mb_write,
    output logic [ADDR_W-1:0] mb_phy,
    output logic [ADDR_W-1:0] mb_reg,
    output logic [DATA_W-1:0] mb_wdata,
    input  logic              mb_done,
    input  logic              mb_err,
    input  logic [DATA_W-1:0] mb_rdata
);
    seq_regs_t         q, d;
    logic [DATA_W-1:0] cmd_word;
    logic              poll_clr, poll_step, poll_last;
    logic              fin, fin_err;
    logic [DATA_W-1:0] fin_data;

    smi_cmd_fmt u_fmt (
        .is_write (q.wr),
        .dev      (q.dev),
        .rg       (q.rg),
        .word     (cmd_word)
    );

    smi_poll_limit #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .step  (poll_step),
        .last  (poll_last)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        d.rdata   = '0;
        poll_clr  = 1'b0;
        poll_step = 1'b0;
        fin       = 1'b0;
        fin_err   = 1'b0;
        fin_data  = '0;
        mb_write  = 1'b0;
        mb_phy    = q.bus;
        mb_reg    = REG_CMD;
        mb_wdata  = '0;

        case (q.st)
            S_IDLE: begin
                poll_clr = 1'b1;
                if (req_valid) begin
                    d.bus   = cfg_bus_addr;
                    d.dev   = req_dev;
                    d.rg    = req_reg;
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                    d.st    = (cfg_bus_addr == '0) ? S_DIRECT : S_PRE_POLL;
                end
            end
            S_DIRECT: begin
                mb_write = q.wr;
                mb_phy   = q.dev;
                mb_reg   = q.rg;
                mb_wdata = q.wdata;
                if (mb_done) begin
                    fin      = 1'b1;
                    fin_err  = mb_err;
                    fin_data = q.wr ? '0 : mb_rdata;
                end
            end
            S_PRE_POLL, S_POST_POLL: begin
                if (mb_done) begin
                    if (mb_err) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (!mb_rdata[BUSY_BIT]) begin
                        poll_clr = 1'b1;
                        if (q.st == S_PRE_POLL)
                            d.st = q.wr ? S_WR_DATA : S_CMD;
                        else if (q.wr)
                            fin = 1'b1;
                        else
                            d.st = S_RD_DATA;
                    end else if (poll_last) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        poll_step = 1'b1;
                    end
                end
            end
            S_WR_DATA: begin
                mb_write = 1'b1;
                mb_reg   = REG_DATA;
                mb_wdata = q.wdata;
                if (mb_done) begin
                    if (mb_err) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        d.st = S_CMD;
                    end
                end
            end
            S_CMD: begin
                mb_write = 1'b1;
                mb_wdata = cmd_word;
                if (mb_done) begin
                    if (mb_err) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        poll_clr = 1'b1;
                        d.st     = S_POST_POLL;
                    end
                end
            end
            S_RD_DATA: begin
                mb_reg = REG_DATA;
                if (mb_done) begin
                    fin      = 1'b1;
                    fin_err  = mb_err;
                    fin_data = mb_rdata;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            d.st    = S_IDLE;
            d.done  = 1'b1;
            d.err   = fin_err;
            d.rdata = fin_err ? '0 : fin_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign mb_valid  = (q.st != S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign rdata     = q.rdata;

    a_r1_direct_target: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && q.bus == '0) |-> (mb_phy == q.dev && mb_reg == q.rg && mb_write == q.wr));

    a_r2_indirect_target: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && q.bus != '0) |-> (mb_phy == q.bus && mb_reg <= REG_DATA));

    a_r3_cmd_format: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && q.bus != '0 && mb_write && mb_reg == REG_CMD) |->
        (mb_wdata[15] && mb_wdata[12] && !mb_wdata[14] && !mb_wdata[13]
         && (mb_wdata[11:10] == OP_RD || mb_wdata[11:10] == OP_WR)));

    a_r4_open_with_poll: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mb_valid) && q.bus != '0) |-> (!mb_write && mb_reg == REG_CMD));

    a_r8_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && mb_done && mb_err) |=> (done && err && !mb_valid));

    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && rdata == '0));

    a_r9_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mb_valid);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/smi_indirect_seq_tb_top.sv
module smi_indirect_seq_tb_top;
    localparam int LIMIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_bus_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        done, err;
    logic [15:0] rdata;
    logic        mb_valid, mb_write;
    logic [4:0]  mb_phy, mb_reg;
    logic [15:0] mb_wdata;
    logic        mb_done = 1'b0;
    logic        mb_err = 1'b0;
    logic [15:0] mb_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    smi_indirect_seq #(.POLL_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bus_addr(cfg_bus_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
        .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .err(err), .rdata(rdata),
        .mb_valid(mb_valid), .mb_write(mb_write), .mb_phy(mb_phy),
        .mb_reg(mb_reg), .mb_wdata(mb_wdata), .mb_done(mb_done),
        .mb_err(mb_err), .mb_rdata(mb_rdata)
    );

    // knobs written only by the stimulus process
    int         pre_busy_k  = 0;
    int         post_busy_k = 0;
    int         err_idx_k   = -1;
    logic [4:0] sw_addr_k   = '0;

    // switch / bus model state, written only by the model process
    logic [26:0] log_q[$];
    int          busy_left = 0;
    int          txn_idx = 0;
    int          lat_cnt = 0;
    logic [15:0] dreg = '0;
    int          mon_bad = 0;

    function automatic logic [15:0] data_of(input logic [4:0] dv, input logic [4:0] rg);
        return 16'h5A5A ^ {6'h0, dv, rg};
    endfunction

    function automatic logic [15:0] cmd_of(input logic wr, input logic [4:0] dv, input logic [4:0] rg);
        return 16'h9000 | (wr ? 16'h0400 : 16'h0800) | {6'h0, dv, rg};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mb_done <= 1'b0;
            mb_err  <= 1'b0;
            lat_cnt = 0;
        end else begin
            if (req_valid && req_ready) begin
                busy_left = pre_busy_k;
                txn_idx   = 0;
            end
            if (mb_done) begin
                mb_done <= 1'b0;
                mb_err  <= 1'b0;
                lat_cnt = 0;
            end else if (mb_valid) begin
                if (lat_cnt < 1) begin
                    lat_cnt = lat_cnt + 1;
                end else begin
                    log_q.push_back({mb_write, mb_phy, mb_reg, mb_write ? mb_wdata : 16'h0});
                    mb_done <= 1'b1;
                    if (txn_idx == err_idx_k) begin
                        mb_err   <= 1'b1;
                        mb_rdata <= 16'hFFFF;
                    end else if (mb_phy == sw_addr_k && sw_addr_k != 5'd0) begin
                        if (!mb_write && mb_reg == 5'd0) begin
                            if (busy_left > 0) begin
                                mb_rdata  <= 16'h8000;
                                busy_left = busy_left - 1;
                            end else begin
                                mb_rdata <= 16'h7FFF;
                            end
                        end else if (!mb_write && mb_reg == 5'd1) begin
                            mb_rdata <= dreg;
                        end else if (mb_write && mb_reg == 5'd1) begin
                            dreg <= mb_wdata;
                        end else if (mb_write && mb_reg == 5'd0) begin
                            busy_left = post_busy_k;
                            if (mb_wdata[11:10] == 2'b10)
                                dreg <= data_of(mb_wdata[9:5], mb_wdata[4:0]);
                        end
                    end else begin
                        mb_rdata <= 16'hD000 | {6'h0, mb_phy, mb_reg};
                    end
                    txn_idx = txn_idx + 1;
                end
            end
        end
    end

    // every-cycle reference: ready must be the inverse of bus activity (R9)
    always @(negedge clk) begin
        if (rst_n && (req_ready !== !mb_valid)) begin
            mon_bad = mon_bad + 1;
            $display("FAIL R9 ready=%0b expected %0b", req_ready, !mb_valid);
        end
    end

    logic [26:0] exp_q[$];
    int          base;
    logic        got_err;
    logic [15:0] got_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic e_rd(input logic [4:0] p, input logic [4:0] r);
        exp_q.push_back({1'b0, p, r, 16'h0});
    endtask

    task automatic e_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
        exp_q.push_back({1'b1, p, r, v});
    endtask

    task automatic cmp_log(input string tag);
        int bad = 0;
        chk({tag, " count"}, log_q.size() - base, exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (base + i >= log_q.size() || log_q[base + i] !== exp_q[i]) bad++;
        end
        chk({tag, " sequence"}, bad, 0);
        exp_q.delete();
    endtask

    task automatic do_req(input logic [4:0] dv, input logic [4:0] rg, input logic wr,
                          input logic [15:0] wd, input logic chg, input logic [4:0] ncfg);
        int n = 0;
        base = log_q.size();
        @(negedge clk);
        req_dev = dv; req_reg = rg; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) cfg_bus_addr = ncfg;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 done seen", done, 1'b1);
        got_err = err;
        got_rd  = rdata;
        @(negedge clk);
        chk("R9 done single pulse", done, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", req_ready, 1'b1);
        chk("R9 reset bus idle", mb_valid, 1'b0);
        chk("R9 reset done", done, 1'b0);

        // R1 direct read
        cfg_bus_addr = 5'd0; sw_addr_k = 5'd0;
        e_rd(5'd3, 5'd2);
        do_req(5'd3, 5'd2, 1'b0, 16'h0, 1'b0, 5'd0);
        cmp_log("R1 direct read");
        chk("R1 direct read data", {got_err, got_rd}, {1'b0, 16'hD000 | {6'h0, 5'd3, 5'd2}});

        // R1 direct write
        e_wr(5'd7, 5'd9, 16'h1234);
        do_req(5'd7, 5'd9, 1'b1, 16'h1234, 1'b0, 5'd0);
        cmp_log("R1 direct write");
        chk("R1 direct write resp", {got_err, got_rd}, 17'h0);

        // R2 R3 R4 R5 R10 indirect read, cfg changed mid request
        cfg_bus_addr = 5'h10; sw_addr_k = 5'h10; pre_busy_k = 2; post_busy_k = 1;
        repeat (3) e_rd(5'h10, 5'd0);
        e_wr(5'h10, 5'd0, cmd_of(1'b0, 5'd4, 5'd1));
        repeat (2) e_rd(5'h10, 5'd0);
        e_rd(5'h10, 5'd1);
        do_req(5'd4, 5'd1, 1'b0, 16'h0, 1'b1, 5'd0);
        cmp_log("R5 R10 indirect read");
        chk("R5 indirect read data", {got_err, got_rd}, {1'b0, data_of(5'd4, 5'd1)});

        // R6 R3 indirect write
        cfg_bus_addr = 5'h1B; sw_addr_k = 5'h1B; pre_busy_k = 0; post_busy_k = 2;
        e_rd(5'h1B, 5'd0);
        e_wr(5'h1B, 5'd1, 16'hBEEF);
        e_wr(5'h1B, 5'd0, cmd_of(1'b1, 5'd2, 5'h1F));
        repeat (3) e_rd(5'h1B, 5'd0);
        do_req(5'd2, 5'h1F, 1'b1, 16'hBEEF, 1'b0, 5'd0);
        cmp_log("R6 indirect write");
        chk("R6 indirect write resp", {got_err, got_rd}, 17'h0);

        // R7 timeout in the pre-poll
        pre_busy_k = 10; post_busy_k = 0;
        repeat (LIMIT) e_rd(5'h1B, 5'd0);
        do_req(5'd5, 5'd3, 1'b0, 16'h0, 1'b0, 5'd0);
        cmp_log("R7 pre-poll timeout");
        chk("R7 pre-poll timeout resp", {got_err, got_rd}, {1'b1, 16'h0});
        repeat (3) @(negedge clk);
        chk("R7 idle after timeout", {req_ready, mb_valid}, 2'b10);

        // R7 timeout in the post-poll
        pre_busy_k = 0; post_busy_k = 10;
        e_rd(5'h1B, 5'd0);
        e_wr(5'h1B, 5'd0, cmd_of(1'b0, 5'd6, 5'd6));
        repeat (LIMIT) e_rd(5'h1B, 5'd0);
        do_req(5'd6, 5'd6, 1'b0, 16'h0, 1'b0, 5'd0);
        cmp_log("R7 post-poll timeout");
        chk("R7 post-poll timeout resp", {got_err, got_rd}, {1'b1, 16'h0});

        // R8 bus error on the command write
        post_busy_k = 0; err_idx_k = 1;
        e_rd(5'h1B, 5'd0);
        e_wr(5'h1B, 5'd0, cmd_of(1'b0, 5'd1, 5'd8));
        do_req(5'd1, 5'd8, 1'b0, 16'h0, 1'b0, 5'd0);
        cmp_log("R8 indirect bus error");
        chk("R8 indirect bus error resp", {got_err, got_rd}, {1'b1, 16'h0});

        // R8 bus error on a direct read
        cfg_bus_addr = 5'd0; sw_addr_k = 5'd0; err_idx_k = 0;
        e_rd(5'd9, 5'd4);
        do_req(5'd9, 5'd4, 1'b0, 16'h0, 1'b0, 5'd0);
        cmp_log("R8 direct bus error");
        chk("R8 direct bus error resp", {got_err, got_rd}, {1'b1, 16'h0});
        err_idx_k = -1;

        chk("R9 ready vs bus activity every cycle", mon_bad, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors + mon_bad);
        $finish;
    end
endmodule